// File: doc/BRIEF.md
# Scatter Accumulator with Drain-and-Clear

This block sums a stream of pixel samples into an on-chip array of output bins. Each sample enters together with a valid flag. The bin address for that sample is produced elsewhere and reaches the block a fixed number of cycles later. The block delays the sample to line up with its address. It then performs a read-modify-write on the bin: it reads the stored sum, adds the sample and writes the result back. Samples that hit the same bin in consecutive cycles are first folded into a held run total. That run total is merged with the stored value once the address changes or the stream pauses. A bypass from the write stage covers the case where a bin is read again right after it was written.

When a frame has been fed in, a drain request streams every bin out in ascending address order, one per cycle, and writes zero into each location as it passes. The next frame therefore starts from empty. The same sweep, without output, runs once after reset. One instance serves one colour channel. Setting `COUNT_ONLY` gives the narrow variant that counts contributions per bin and ignores the sample value.

Top module: `scatter_accum`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 2^ADDR_W cycles while every bin is cleared. `out_valid` stays low during this sweep. A drain that follows returns zero for every bin.
- R2: A sample presented with `in_valid` in cycle t is summed into the bin given on `in_addr` in cycle t+ALIGN_DLY (default 5). The value on `in_addr` in cycle t does not matter.
- R3: After any mix of samples and idle cycles, each bin holds the sum of every sample directed to it.
- R4: A run of consecutive samples to one bin loses no contribution.
- R5: A bin sum saturates at 2^SUM_W-1 and does not wrap. SUM_W = DATA_W + ceil(log2(MAX_HITS)) in data mode, and 1 + ceil(log2(MAX_HITS)) in count mode.
- R6: A bin is summed correctly when it is hit again one or two samples after its run ended. This covers the patterns A,B,A and A,idle,A.
- R7: A drain request yields exactly 2^ADDR_W beats with `out_valid` high on consecutive cycles. `out_addr` runs 0,1,2,… and `out_sum` carries that bin's total. `busy` is low once the drain ends.
- R8: A drain leaves every bin at zero, so a second drain with no samples in between returns all zeros.
- R9: `dump_start` is ignored while `busy` is high or while any accepted sample has not yet been written to memory. No beat is produced and the sums are kept.
- R10: Samples whose aligned cycle falls while `busy` is high are discarded.
- R11: With COUNT_ONLY=1 each sample adds one to its bin regardless of `in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | DATA_W | Sample value |
| in_addr | input | ADDR_W | Bin address for the sample presented ALIGN_DLY cycles earlier |
| dump_start | input | 1 | Request to drain and clear all bins |
| busy | output | 1 | Clearing sweep or drain in progress |
| out_valid | output | 1 | Drain beat present |
| out_addr | output | ADDR_W | Bin address of the drain beat |
| out_sum | output | SUM_W | Bin total of the drain beat |

## Verification
The bench goes after these cases:
- Back-to-back hits on one bin. A design that reads memory per sample without the held run would drop all but one of them.
- Revisits after one intervening sample or one idle cycle. Without the write-stage bypass these return the stale pre-write sum.
- Bins driven past full scale. Wrapping arithmetic would show up there as a small value.
- A second drain straight after the first, and samples pushed in during a drain. These expose a drain that forgets to erase, or one that lets stray writes land.
- A drain request made while samples are still in flight. An early start would emit partial sums.

// File: rtl/scatter_accum_pkg.sv
package scatter_accum_pkg;
  typedef enum logic [1:0] {
    SA_CLEAR = 2'd0,
    SA_IDLE  = 2'd1,
    SA_DUMP  = 2'd2
  } sa_mode_t;
endpackage

// File: rtl/sa_align_delay.sv
module sa_align_delay #(
  parameter int DW    = 8,
  parameter int DEPTH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          pending
);
  logic [DEPTH-1:0] v_q;
  logic [DW-1:0]    d_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < DEPTH; i++) d_q[i] <= '0;
    end else begin
      v_q[0] <= in_valid;
      d_q[0] <= in_data;
      for (int i = 1; i < DEPTH; i++) begin
        v_q[i] <= v_q[i-1];
        d_q[i] <= d_q[i-1];
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];
  assign pending   = |v_q;
endmodule

// File: rtl/sa_run_merge.sv
module sa_run_merge #(
  parameter int AW = 6,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [AW-1:0] s_addr,
  input  logic [SW-1:0] s_val,
  output logic [AW-1:0] rd_addr,
  input  logic [SW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [SW-1:0] wr_data,
  output logic          pending
);
  function automatic logic [SW-1:0] sat_add(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[SW] ? {SW{1'b1}} : s[SW-1:0];
  endfunction

  logic          run_valid;
  logic [AW-1:0] run_addr;
  logic [SW-1:0] run_sum;
  logic [SW-1:0] run_base;
  logic          base_fresh;

  // named internal events
  logic          run_hit, run_start, commit_fire;
  logic [SW-1:0] base_now, commit_sum;

  assign run_hit     = s_valid && run_valid && (s_addr == run_addr);
  assign run_start   = s_valid && !run_hit;
  assign commit_fire = run_valid && !run_hit;
  assign base_now    = base_fresh ? rd_data : run_base;
  assign commit_sum  = sat_add(base_now, run_sum);
  assign rd_addr     = s_addr;
  assign pending     = run_valid || wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_valid  <= 1'b0;
      run_addr   <= '0;
      run_sum    <= '0;
      run_base   <= '0;
      base_fresh <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      if (run_hit) begin
        run_sum <= sat_add(run_sum, s_val);
      end else if (run_start) begin
        run_valid <= 1'b1;
        run_addr  <= s_addr;
        run_sum   <= s_val;
      end else if (commit_fire) begin
        run_valid <= 1'b0;
      end
      base_fresh <= run_start;
      if (base_fresh) run_base <= rd_data;
      wr_en   <= commit_fire;
      wr_addr <= run_addr;
      wr_data <= commit_sum;
    end
  end

  assert_commit_ge_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data >= $past(run_sum));
  assert_run_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_hit |=> run_sum >= $past(run_sum));
endmodule

// File: rtl/sa_bin_mem.sv
module sa_bin_mem #(
  parameter int AW = 6,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [SW-1:0] wd,
  input  logic [AW-1:0] ra,
  input  logic          byp_en,
  output logic [SW-1:0] rd_raw,
  output logic [SW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [SW-1:0] mem [DEPTH];
  logic          byp_q;
  logic [SW-1:0] byp_data_q;

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_raw <= mem[ra];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q      <= 1'b0;
      byp_data_q <= '0;
    end else begin
      byp_q      <= byp_en && we && (wa == ra);
      byp_data_q <= wd;
    end
  end

  assign rd_data = byp_q ? byp_data_q : rd_raw;

  assert_bypass_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && $past(byp_en) && ($past(wa) == $past(ra))) |-> rd_data == $past(wd));
endmodule

// File: rtl/scatter_accum.sv
module scatter_accum
  import scatter_accum_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int MAX_HITS   = 256,
  parameter int ALIGN_DLY  = 5,
  parameter bit COUNT_ONLY = 1'b0,
  localparam int VAL_W     = COUNT_ONLY ? 1 : DATA_W,
  localparam int SUM_W     = VAL_W + $clog2(MAX_HITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              dump_start,
  output logic              busy,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SUM_W-1:0]  out_sum
);
  localparam int BINS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BINS - 1);

  sa_mode_t          mode;
  logic [ADDR_W-1:0] cnt;
  logic              ov_q;
  logic [ADDR_W-1:0] oa_q;

  logic              al_valid, dly_pending;
  logic [DATA_W-1:0] al_data;
  logic              s_valid;
  logic [SUM_W-1:0]  s_val;
  logic [ADDR_W-1:0] m_rd_addr, m_wr_addr;
  logic              m_we, m_pending;
  logic [SUM_W-1:0]  m_wd;
  logic              mem_we, byp_en;
  logic [ADDR_W-1:0] mem_wa, mem_ra;
  logic [SUM_W-1:0]  mem_wd, rd_raw, rd_data;
  logic              dump_go;

  sa_align_delay #(.DW(DATA_W), .DEPTH(ALIGN_DLY)) u_align (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(al_valid), .out_data(al_data), .pending(dly_pending));

  assign s_valid = al_valid && (mode == SA_IDLE);
  assign s_val   = COUNT_ONLY ? SUM_W'(1) : SUM_W'(al_data);

  sa_run_merge #(.AW(ADDR_W), .SW(SUM_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_addr(in_addr), .s_val(s_val),
    .rd_addr(m_rd_addr), .rd_data(rd_data), .wr_en(m_we), .wr_addr(m_wr_addr),
    .wr_data(m_wd), .pending(m_pending));

  always_comb begin
    if (mode == SA_IDLE) begin
      mem_we = m_we;
      mem_wa = m_wr_addr;
      mem_wd = m_wd;
      mem_ra = m_rd_addr;
      byp_en = 1'b1;
    end else begin
      mem_we = 1'b1;
      mem_wa = cnt;
      mem_wd = '0;
      mem_ra = cnt;
      byp_en = 1'b0;
    end
  end

  sa_bin_mem #(.AW(ADDR_W), .SW(SUM_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .wa(mem_wa), .wd(mem_wd), .ra(mem_ra),
    .byp_en(byp_en), .rd_raw(rd_raw), .rd_data(rd_data));

  assign dump_go = (mode == SA_IDLE) && dump_start && !dly_pending && !m_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= SA_CLEAR;
      cnt  <= '0;
      ov_q <= 1'b0;
      oa_q <= '0;
    end else begin
      ov_q <= (mode == SA_DUMP);
      oa_q <= cnt;
      unique case (mode)
        SA_CLEAR, SA_DUMP: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) mode <= SA_IDLE;
        end
        SA_IDLE: if (dump_go) begin
          mode <= SA_DUMP;
          cnt  <= '0;
        end
        default: mode <= SA_IDLE;
      endcase
    end
  end

  assign busy      = (mode != SA_IDLE);
  assign out_valid = ov_q;
  assign out_addr  = oa_q;
  assign out_sum   = ov_q ? rd_raw : '0;

  assert_drain_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> out_addr == $past(out_addr) + 1'b1);
  assert_no_write_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != SA_IDLE) |-> !m_we);
  assert_drain_after_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == SA_DUMP) |-> $past(!dly_pending && !m_pending && dump_start));
  assert_quiet_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mode == SA_DUMP));
endmodule

// File: tb/scatter_accum_test.sv
module scatter_accum_test;
  localparam int AW = 4, DW = 8, MH = 4, DLY = 5, BINS = 16;
  localparam int SW = DW + $clog2(MH);
  localparam int CW = 1 + $clog2(MH);
  localparam int SMAX = (1 << SW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, dump_start = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] in_addr = '0;
  logic busy, out_valid, c_busy, c_out_valid;
  logic [AW-1:0] out_addr, c_out_addr;
  logic [SW-1:0] out_sum;
  logic [CW-1:0] c_out_sum;

  always #4 clk = ~clk;

  scatter_accum #(.ADDR_W(AW), .DATA_W(DW), .MAX_HITS(MH), .ALIGN_DLY(DLY), .COUNT_ONLY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_addr(in_addr),
    .dump_start(dump_start), .busy(busy), .out_valid(out_valid), .out_addr(out_addr), .out_sum(out_sum));
  scatter_accum #(.ADDR_W(AW), .DATA_W(DW), .MAX_HITS(MH), .ALIGN_DLY(DLY), .COUNT_ONLY(1'b1)) uut_cnt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_addr(in_addr),
    .dump_start(dump_start), .busy(c_busy), .out_valid(c_out_valid), .out_addr(c_out_addr), .out_sum(c_out_sum));

  int errors = 0, checks = 0;
  int exp_s[BINS], exp_c[BINS];
  bit st_v[512];
  int st_a[512], st_d[512];
  int st_n = 0;

  function automatic int sat(int a, int b, int m);
    return (a + b > m) ? m : a + b;
  endfunction

  task automatic check(bit ok, string r, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", r, what, act, expv);
    end
  endtask

  task automatic add(bit v, int a, int d);
    st_v[st_n] = v; st_a[st_n] = a; st_d[st_n] = d; st_n++;
    if (v) begin
      exp_s[a] = sat(exp_s[a], d, SMAX);
      exp_c[a] = sat(exp_c[a], 1, CMAX);
    end
  endtask

  // drives st_*; addresses lag data by DLY cycles; optional early drain request
  task automatic run_stream(int dump_at);
    int seen = 0;
    for (int k = 0; k < st_n + DLY + 4; k++) begin
      @(negedge clk);
      if (out_valid || busy) seen++;
      in_valid   = (k < st_n) ? st_v[k] : 1'b0;
      in_data    = (k < st_n) ? DW'(st_d[k]) : DW'($urandom);
      in_addr    = (k >= DLY && k - DLY < st_n) ? AW'(st_a[k-DLY]) : AW'($urandom);
      dump_start = (k == dump_at);
    end
    @(negedge clk);
    in_valid = 1'b0; dump_start = 1'b0;
    if (dump_at >= 0) check(seen == 0, "R9", "beats or busy after early drain request", seen, 0);
    st_n = 0;
  endtask

  task automatic do_dump(string r, bit inject);
    int beat = 0;
    @(negedge clk); dump_start = 1'b1;
    @(negedge clk); dump_start = 1'b0;
    for (int t = 0; t < BINS + 12; t++) begin
      if (inject && t < 8) begin
        in_valid = 1'b1; in_data = 8'd77; in_addr = 4'd5;
      end else if (inject && t < 14) begin
        in_valid = 1'b0; in_addr = 4'd5;
      end else in_valid = 1'b0;
      if (out_valid) begin
        check(out_addr == AW'(beat), "R7", "drain address", int'(out_addr), beat);
        check(int'(out_sum) == exp_s[beat], r, $sformatf("bin %0d sum", beat), int'(out_sum), exp_s[beat]);
        check(c_out_valid && int'(c_out_sum) == exp_c[beat], "R11", $sformatf("bin %0d count", beat),
              int'(c_out_sum), exp_c[beat]);
        beat++;
      end
      @(negedge clk);
    end
    check(beat == BINS, "R7", "drain beat count", beat, BINS);
    check(!busy, "R7", "busy after drain", int'(busy), 0);
    for (int i = 0; i < BINS; i++) begin exp_s[i] = 0; exp_c[i] = 0; end
  endtask

  initial begin
    int n = 0, ovs = 0;
    void'($urandom(32'd4242));
    for (int i = 0; i < BINS; i++) begin exp_s[i] = 0; exp_c[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (busy && n < 200) begin
      n++;
      if (out_valid) ovs++;
      @(negedge clk);
    end
    check(n == BINS, "R1", "clear sweep length", n, BINS);
    check(ovs == 0, "R1", "beats during clear", ovs, 0);
    do_dump("R1", 1'b0);

    // R2/R4/R6 directed: runs, revisit after one sample, revisit after idle
    add(1, 2, 10); add(1, 2, 20); add(1, 2, 30); add(1, 2, 40);
    add(1, 7, 5);  add(1, 2, 1);  add(1, 7, 6);
    add(1, 9, 3);  add(0, 0, 0);  add(1, 9, 4);  add(0, 0, 0); add(1, 9, 8);
    add(1, 11, 100); add(1, 12, 1); add(1, 13, 1); add(1, 11, 100);
    run_stream(-1);
    do_dump("R4/R6/R2", 1'b0);

    // R5 saturation: long run and split runs
    for (int i = 0; i < 9; i++) add(1, 3, 255);
    for (int i = 0; i < 6; i++) begin add(1, 4, 255); add(1, 6, 200); end
    run_stream(-1);
    do_dump("R5", 1'b0);

    // R3 random frames
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 48; i++)
        add(($urandom_range(0, 3) != 0), (f == 0) ? $urandom_range(0, 3) : $urandom_range(0, BINS - 1),
            $urandom_range(0, 255));
      run_stream(-1);
      do_dump("R3", 1'b0);
    end

    // R9 early drain request while samples in flight
    for (int i = 0; i < 10; i++) add(1, i, 11 * i + 3);
    run_stream(11);
    do_dump("R9", 1'b0);

    // R8 then R10: drain with stray samples, then a second drain must be empty
    add(1, 1, 42); add(1, 1, 1);
    run_stream(-1);
    do_dump("R8", 1'b1);
    do_dump("R10", 1'b0);
    do_dump("R8", 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule